// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block serialises one character at a time onto a single transmit line. Software writes a character into the data register. The block then frames it with a low start bit, the data bits sent least-significant first, an optional parity bit and a high stop bit. Each bit lasts exactly one period of an external baud tick. A mode bit selects between a short character of DATA_W-1 bits and a full character of DATA_W bits. Parity can be turned off, or set to even or odd.

Before a frame begins, the block waits for the clear-to-send input. The input first passes through a synchroniser. A control bit lets software ignore the input, and then frames start at once. A low clear-to-send input only holds off the start of a frame. A frame that has begun always runs to its stop bit.

Software can read the synchronised clear-to-send level from the control register. A sticky change flag records every change of that level. Software clears the flag by writing zero to its bit. The flag drives an interrupt through a mask bit.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `irq` is 0. All writable control fields (bits 4:0 at address 1) read 0. The clear-to-send status bit (bit 5) and the change flag (bit 6) read 0 while `ctsIn` is held low.
- R2: A frame is one start bit (0), then the data bits LSB first, then the parity bit if enabled, then one stop bit (1). `txd` changes only on clocks where `baudTick` is 1, and holds 1 whenever no frame is in progress.
- R3: Control bit 1 selects the character length. With the bit at 0, DATA_W-1 bits are sent and the top data bit is ignored. With the bit at 1, all DATA_W bits are sent. The length is captured when the character is accepted.
- R4: Control bit 2 enables parity and control bit 3 selects odd parity. The parity bit is the XOR of the transmitted data bits. With odd parity selected, that XOR is inverted.
- R5: A write to address 0 while idle accepts `regWrData` as the next character. `busy` rises on the following clock and stays high until the baud tick that ends the stop bit. A write to address 0 while `busy` is high is ignored.
- R6: While control bit 0 (ignore clear-to-send) is 1, a pending character starts on the next baud tick, whatever the level of `ctsIn`.
- R7: While control bit 0 is 0, the start bit is held off until the synchronised clear-to-send level is 1. If `ctsIn` falls during a frame, the frame still completes.
- R8: Bit 5 at address 1 reads the level of `ctsIn` after a SYNC_STAGES-flop synchroniser. A value of 1 means high.
- R9: Bit 6 at address 1 sets to 1 one clock after any change of the synchronised level, and stays set. It clears when a write to address 1 carries 0 in bit 6. A write carrying 1 in bit 6 leaves it unchanged.
- R10: If a clearing write and a synchronised level change fall in the same clock, bit 6 stays set.
- R11: `irq` equals bit 6 AND control bit 4 (the interrupt mask) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 1 | Register select: 0 = data, 1 = control/status |
| regWr | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register: address 0 gives {0, busy}; address 1 gives {busy, change flag, cts status, mask, odd, parity enable, full length, ignore} |
| baudTick | input | 1 | One-clock pulse per bit period |
| ctsIn | input | 1 | Clear-to-send input, asserted high, asynchronous |
| txd | output | 1 | Serial output |
| irq | output | 1 | Masked clear-to-send change interrupt |
| busy | output | 1 | A character is pending or being sent |

## Verification
On every cycle, the assertions check four things. The line stays high whenever the block is idle. A start strobe is always followed by a low line. The change flag can only drop when the control logic asks for a clear. `busy` can only rise after an accepted data write. They also check that a pending frame stays parked while clear-to-send is low and not ignored. Only the bench's scenarios can show that the bit order, character length and parity of whole frames are right. The same holds for a clear-to-send drop in mid-frame, a write ignored while busy, and a clear that collides with a level change. All of these are compared against a behavioural model on every clock.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef struct packed {
    logic load;      // capture a new character
    logic loadFull;  // full-length character at load
    logic start;     // drive start bit
    logic shift;     // drive next data bit
    logic parity;    // drive parity bit
    logic parOdd;    // odd parity select, valid with parity
    logic stop;      // drive stop bit
    logic deltaClr;  // software clear of change flag
  } txStrobes_t;
endpackage

// File: rtl/uart_cts_dp.sv
module uart_cts_dp
  import uart_cts_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        stb,
  input  logic [DATA_W-1:0] charIn,
  input  logic              ctsIn,
  output logic              txd,
  output logic              ctsSync,
  output logic              ctsDelta
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   ctsPrev;
  logic [DATA_W-1:0]      shiftQ;
  logic                   parAcc;
  logic                   levelChange;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= ctsIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ctsIn};
    end
  endgenerate

  assign ctsSync     = syncQ[SYNC_STAGES-1];
  assign levelChange = ctsSync ^ ctsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPrev  <= 1'b0;
      ctsDelta <= 1'b0;
    end else begin
      ctsPrev <= ctsSync;
      if (levelChange)       ctsDelta <= 1'b1;
      else if (stb.deltaClr) ctsDelta <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parAcc <= 1'b0;
      txd    <= 1'b1;
    end else begin
      if (stb.load) begin
        shiftQ <= stb.loadFull ? charIn : {1'b0, charIn[DATA_W-2:0]};
        parAcc <= 1'b0;
      end
      if (stb.start) txd <= 1'b0;
      if (stb.shift) begin
        txd    <= shiftQ[0];
        parAcc <= parAcc ^ shiftQ[0];
        shiftQ <= shiftQ >> 1;
      end
      if (stb.parity) txd <= parAcc ^ stb.parOdd;
      if (stb.stop)   txd <= 1'b1;
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> !txd);
  p_delta_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctsDelta && !stb.deltaClr) |=> ctsDelta);
endmodule

// File: rtl/uart_cts_ctrl.sv
module uart_cts_ctrl
  import uart_cts_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       baudTick,
  input  logic       ctsSync,
  input  logic       ctsDelta,
  output txStrobes_t stb,
  output logic       busy,
  output logic       irq
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_PAR, ST_STOP, ST_LAST} txState_t;

  txState_t       state;
  logic [IDX_W-1:0] bitIdx;
  logic ignoreCts, fullLen, parEn, parOdd, irqMask;
  logic curFull, curParEn, curOdd;
  logic dataWr, ctrlWr, ctsOk;

  assign dataWr = regWr && !regAddr;
  assign ctrlWr = regWr && regAddr;
  assign ctsOk  = ignoreCts || ctsSync;
  assign busy   = (state != ST_IDLE);
  assign irq    = ctsDelta && irqMask;

  always_comb begin
    stb          = '0;
    stb.load     = dataWr && (state == ST_IDLE);
    stb.loadFull = fullLen;
    stb.start    = baudTick && (state == ST_WAIT) && ctsOk;
    stb.shift    = baudTick && (state == ST_DATA);
    stb.parity   = baudTick && (state == ST_PAR);
    stb.parOdd   = curOdd;
    stb.stop     = baudTick && (state == ST_STOP);
    stb.deltaClr = ctrlWr && !regWrData[6];
  end

  always_comb begin
    if (regAddr) regRdData = {busy, ctsDelta, ctsSync, irqMask, parOdd, parEn, fullLen, ignoreCts};
    else         regRdData = {7'b0, busy};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {ignoreCts, fullLen, parEn, parOdd, irqMask} <= '0;
    end else if (ctrlWr) begin
      {irqMask, parOdd, parEn, fullLen, ignoreCts} <= regWrData[4:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      curFull  <= 1'b0;
      curParEn <= 1'b0;
      curOdd   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (stb.load) begin
          state    <= ST_WAIT;
          curFull  <= fullLen;
          curParEn <= parEn;
          curOdd   <= parOdd;
        end
        ST_WAIT: if (stb.start) begin
          state  <= ST_DATA;
          bitIdx <= '0;
        end
        ST_DATA: if (baudTick) begin
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == (curFull ? LAST_FULL : LAST_SHORT))
            state <= curParEn ? ST_PAR : ST_STOP;
        end
        ST_PAR:  if (baudTick) state <= ST_STOP;
        ST_STOP: if (baudTick) state <= ST_LAST;
        ST_LAST: if (baudTick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataWr));
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !ignoreCts && !ctsSync) |=> (state == ST_WAIT));
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       baudTick,
  input  logic       ctsIn,
  output logic       txd,
  output logic       irq,
  output logic       busy
);
  txStrobes_t stb;
  logic ctsSync, ctsDelta;

  uart_cts_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .baudTick(baudTick),
    .ctsSync(ctsSync), .ctsDelta(ctsDelta), .stb(stb), .busy(busy), .irq(irq)
  );

  uart_cts_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .charIn(regWrData[DATA_W-1:0]),
    .ctsIn(ctsIn), .txd(txd), .ctsSync(ctsSync), .ctsDelta(ctsDelta)
  );

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);
endmodule

// File: tb/uart_cts_tx_bench.sv
module uart_cts_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic regAddr = 1'b1, regWr = 1'b0, baudTick = 1'b0, ctsIn = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic txd, irq, busy;

  int compared = 0, mismatched = 0, cycles = 0, tickCnt = 0;
  string curReq = "R2";

  uart_cts_tx u_uart_cts_tx (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .baudTick(baudTick),
    .ctsIn(ctsIn), .txd(txd), .irq(irq), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt  = (tickCnt + 1) % TICK_DIV;
    baudTick = (tickCnt == 0);
  end

  // behavioural reference model
  bit mIgn, mFull, mPar, mOdd, mMask, mS1, mS2, mS3, mDelta, mBusy, mWait, mTxd = 1'b1;
  bit q[$];

  always @(posedge clk) begin
    if (!rstN) begin
      {mIgn, mFull, mPar, mOdd, mMask, mS1, mS2, mS3, mDelta, mBusy, mWait} = '0;
      mTxd = 1'b1;
      q.delete();
    end else begin
      automatic bit chg = (mS2 != mS3);
      if (chg) mDelta = 1'b1;
      else if (regWr && regAddr && !regWrData[6]) mDelta = 1'b0;
      if (!mBusy) begin
        if (regWr && !regAddr) begin
          automatic int n = mFull ? 8 : 7;
          automatic bit p = mOdd;
          q.delete();
          q.push_back(1'b0);
          for (int i = 0; i < n; i++) begin q.push_back(regWrData[i]); p ^= regWrData[i]; end
          if (mPar) q.push_back(p);
          q.push_back(1'b1);
          mBusy = 1'b1; mWait = 1'b1;
        end
      end else if (baudTick) begin
        if (mWait) begin
          if (mIgn || mS2) begin mTxd = q.pop_front(); mWait = 1'b0; end
        end else if (q.size() > 0) mTxd = q.pop_front();
        else mBusy = 1'b0;
      end
      if (regWr && regAddr) {mMask, mOdd, mPar, mFull, mIgn} = regWrData[4:0];
      mS3 = mS2; mS2 = mS1; mS1 = ctsIn;
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #(CLK_PERIOD/4);
    if (rstN) begin
      check(curReq, txd, mTxd);
      check("R5", busy, mBusy);
      check("R11", irq, mDelta & mMask);
      if (regAddr) begin
        check("R1", regRdData[4:0], {mMask, mOdd, mPar, mFull, mIgn});
        check("R8", regRdData[5], mS2);
        check("R9", regRdData[6], mDelta);
        check("R5", regRdData[7], mBusy);
      end else check("R5", regRdData, {7'b0, mBusy});
    end
  end

  task automatic regWrite(bit addr, logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regWr = 1'b1; regWrData = data;
    @(negedge clk);
    regWr = 1'b0; regAddr = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", txd, 1); check("R1", busy, 0); check("R1", irq, 0);
    check("R1", regRdData, 8'h00);

    // R6 / R2: ignore CTS, 8-bit, no parity
    curReq = "R6";
    regWrite(1, 8'h43);
    regWrite(0, 8'hA5);
    waitIdle();

    // R3: 7-bit mode drops top bit, even parity (R4)
    curReq = "R3";
    regWrite(1, 8'h45);
    regWrite(0, 8'hFF);
    waitIdle();

    // R4: odd parity, 8-bit
    curReq = "R4";
    regWrite(1, 8'h4F);
    regWrite(0, 8'h3C);
    waitIdle();

    // R5: write while busy ignored
    curReq = "R5";
    regWrite(0, 8'h81);
    regWrite(0, 8'h7E);
    waitIdle();

    // R7: held off while CTS low, not ignored; mask on for R11
    curReq = "R7";
    regWrite(1, 8'h52);
    regWrite(0, 8'h96);
    repeat (30) @(negedge clk);
    check("R7", txd, 1); check("R7", busy, 1);
    ctsIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", regRdData[5], 1);
    check("R11", irq, 1);
    repeat (12) @(negedge clk);
    ctsIn = 1'b0;               // drop mid frame: frame completes
    waitIdle();
    check("R7", busy, 0);

    // R9: write 1 keeps flag, write 0 clears it
    regWrite(1, 8'h52);
    check("R9", regRdData[6], 1);
    regWrite(1, 8'h12);
    check("R9", regRdData[6], 0);
    check("R11", irq, 0);

    // R10: clear collides with a synchronised change
    @(negedge clk); ctsIn = 1'b1;
    @(negedge clk);
    regWrite(1, 8'h12);
    @(negedge clk);
    check("R10", regRdData[6], 1);
    regWrite(1, 8'h12);
    @(negedge clk); ctsIn = 1'b0;
    @(negedge clk);
    regWrite(1, 8'h12);
    @(negedge clk);
    check("R10", regRdData[6], 1);

    // R7: CTS high then frames go out normally
    curReq = "R2";
    ctsIn = 1'b1;
    repeat (4) @(negedge clk);
    regWrite(0, 8'h5A);
    waitIdle();

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule